// File: doc/BRIEF.md
# Sequential nonrestoring binary divider

The block divides a signed dividend by a positive divisor and delivers one quotient digit per clock from a single shared add/subtract cell. The divisor Y is an unsigned `DATA_W`-bit value greater than zero. The dividend X is a `DATA_W+1`-bit two's-complement value limited to −Y ≤ X < Y. The block produces a fixed-point quotient with `QUO_W` fraction bits. Each step doubles the partial remainder and then adds or subtracts the divisor, depending on the sign of the remainder. A final correction cycle makes the remainder non-negative and adjusts the quotient to match.

A client drives the operands together with a one-cycle `start_i` while the block is idle. The block raises `busy_o` for the length of the operation. It then pulses `done_o` and holds the quotient and remainder on its outputs until the next start. A zero divisor and a dividend outside the allowed range are not supported.

Top module: `nrdiv_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `quotient_o` and `remainder_o` are all zero.
- R2: A `start_i` sampled high while `busy_o` is low captures both operands, and `busy_o` is high in the following cycle.
- R3: Each iteration shifts the partial remainder left by one and inserts a zero. It then adds Y when the remainder is negative and subtracts Y otherwise. The partial remainder stays within [−Y, Y).
- R4: The results satisfy X·2^QUO_W = Q·Y + R with 0 ≤ R < Y. Q is `quotient_o`, read as a `QUO_W+1`-bit two's-complement number. R is `remainder_o`, read unsigned.
- R5: If start is sampled at clock edge k, `busy_o` stays high until edge k+QUO_W+1. `done_o` is high only in the cycle after that edge, and for exactly one cycle.
- R6: While `busy_o` is high, `start_i`, `dividend_i` and `divisor_i` are ignored. The results that follow belong to the operands captured at the accepted start.
- R7: After `done_o`, the results stay stable until the next accepted start.
- R8: X = −Y yields Q = −2^QUO_W and R = 0. X = Y−1 yields Q = floor((Y−1)·2^QUO_W / Y) with the matching remainder. X = 0 yields Q = 0 and R = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a division (taken only while idle) |
| dividend_i | input | DATA_W+1 | Signed dividend X |
| divisor_i | input | DATA_W | Positive divisor Y |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | QUO_W+1 | Signed quotient Q |
| remainder_o | output | DATA_W | Non-negative remainder R |

## Verification
A start sampled at edge k produces `busy_o` after edge k. It produces `done_o` together with valid results after edge k+QUO_W+1. The bench drives inputs on falling edges and samples on falling edges. It checks `busy_o` and the absence of `done_o` at each of the first QUO_W+1 falling edges after the one that drove start. At the next falling edge it checks `done_o` and both results. The tests for held results and ignored inputs sample several cycles later. By then any disturbance would already have reached the outputs.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_cell.sv
module nrdiv_cell #(
  parameter int unsigned W = 8
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] div_i,
  input  logic         add_i,
  output logic [W:0]   rem_o
);
  logic [W:0] dbl;
  logic [W:0] ext_div;

  // top bit is dropped on purpose: result always fits in W+1 bits
  assign dbl     = {rem_i[W-1:0], 1'b0};
  assign ext_div = {1'b0, div_i};

  always_comb begin
    if (add_i) rem_o = dbl + ext_div;
    else       rem_o = dbl - ext_div;
  end
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
  parameter int unsigned W  = 8,
  parameter int unsigned QW = 8
) (
  input  logic [W:0]    rem_i,
  input  logic [W-1:0]  div_i,
  input  logic [QW-1:0] qbits_i,
  output logic [QW:0]   quo_o,
  output logic [W-1:0]  rem_o
);
  logic         neg;
  logic [W:0]   rem_sum;
  logic [QW:0]  quo_base;

  assign neg     = rem_i[W];
  assign rem_sum = rem_i + {1'b0, div_i};

  // digits in {-1,+1}: value = 2*qbits - (2^QW - 1)
  assign quo_base = {~qbits_i[QW-1], qbits_i[QW-2:0], 1'b1};

  assign quo_o = quo_base - {{QW{1'b0}}, neg};
  assign rem_o = neg ? rem_sum[W-1:0] : rem_i[W-1:0];
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int unsigned QW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(QW + 1);
  localparam logic [CW-1:0] LAST = CW'(QW - 1);

  nrdiv_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_ITER);
  assign fix_o  = (st_q == ST_FIX);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ITER;
      ST_ITER: if (cnt_q == LAST) st_d = ST_FIX;
      ST_FIX:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fix_o;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R5
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned QUO_W  = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W:0]   dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [QUO_W:0]    quotient_o,
  output logic [DATA_W-1:0] remainder_o
);
  localparam int unsigned RW = DATA_W + 1;

  logic              load, step, fix;
  logic [RW-1:0]     rem_q, rem_nxt;
  logic [DATA_W-1:0] div_q;
  logic [QUO_W-1:0]  qbits_q;
  logic [QUO_W:0]    fix_quo, quo_q;
  logic [DATA_W-1:0] fix_rem, res_rem_q;

  nrdiv_ctrl #(.QW(QUO_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fix_o  (fix),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  nrdiv_cell #(.W(DATA_W)) i_cell (
    .rem_i(rem_q),
    .div_i(div_q),
    .add_i(rem_q[RW-1]),
    .rem_o(rem_nxt)
  );

  nrdiv_fix #(.W(DATA_W), .QW(QUO_W)) i_fix (
    .rem_i  (rem_q),
    .div_i  (div_q),
    .qbits_i(qbits_q),
    .quo_o  (fix_quo),
    .rem_o  (fix_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      div_q     <= '0;
      qbits_q   <= '0;
      quo_q     <= '0;
      res_rem_q <= '0;
    end else begin
      if (load) begin
        rem_q   <= dividend_i;
        div_q   <= divisor_i;
        qbits_q <= '0;
      end else if (step) begin
        rem_q   <= rem_nxt;
        qbits_q <= {qbits_q[QUO_W-2:0], ~rem_q[RW-1]};
      end
      if (fix) begin
        quo_q     <= fix_quo;
        res_rem_q <= fix_rem;
      end
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = res_rem_q;

  AST_REM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step || fix) |->
      ($signed({rem_q[RW-1], rem_q}) >= -$signed({2'b00, div_q}) &&
       $signed({rem_q[RW-1], rem_q}) <  $signed({2'b00, div_q}))); // R3
  AST_REM_BELOW_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (remainder_o < div_q)); // R4
  AST_OPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(div_q)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |=> $stable(quotient_o) && $stable(remainder_o)); // R7
endmodule

// File: tb/test_nrdiv_seq.sv
module test_nrdiv_seq;
  localparam int unsigned DW = 8;
  localparam int unsigned QW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW:0]   dvd = '0;
  logic [DW-1:0] dvs = '0;
  logic          busy, done;
  logic [QW:0]   quo;
  logic [DW-1:0] rem;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  nrdiv_seq #(.DATA_W(DW), .QUO_W(QW)) i_nrdiv_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_div(input longint x, input longint y,
                         output longint q, output longint r);
    longint num;
    num = x * (longint'(1) <<< QW);
    q = num / y;
    if (num % y < 0) q = q - 1;
    r = num - q * y;
  endtask

  // drive on negedge; check busy/done timing and results (R2, R4, R5)
  task automatic run_div(input string tag, input longint x, input longint y);
    longint eq, er;
    ref_div(x, y, eq, er);
    @(negedge clk);
    start = 1'b1; dvd = (DW+1)'(x); dvs = DW'(y);
    for (int j = 1; j <= QW + 1; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0)
        chk({tag, " R5 busy window"}, {busy, done}, 2'b10);
    end
    @(negedge clk);
    chk({tag, " R5 done"}, done, 1);
    chk({tag, " R5 busy low"}, busy, 0);
    chk({tag, " R4 quotient"}, longint'($signed(quo)), eq);
    chk({tag, " R4 remainder"}, longint'(rem), er);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 quotient", quo, 0);
    chk("R1 remainder", rem, 0);
  endtask

  task automatic t_bounds;
    longint ys[4] = '{1, 3, 100, 255};
    foreach (ys[i]) begin
      run_div("R8 x=-y", -ys[i], ys[i]);
      chk("R8 -y quotient", longint'($signed(quo)), -(longint'(1) <<< QW));
      chk("R8 -y remainder", rem, 0);
      run_div("R8 x=y-1", ys[i] - 1, ys[i]);
      run_div("R8 x=0", 0, ys[i]);
    end
    run_div("R8 x=-1", -1, 7);
  endtask

  task automatic t_random;
    for (int i = 0; i < 60; i++) begin
      longint y, x;
      y = 1 + longint'($urandom % 255);
      x = longint'($urandom % 32'(2 * y)) - y;
      run_div("R3 random", x, y);
    end
  endtask

  task automatic t_ignore;
    longint eq, er;
    ref_div(-37, 91, eq, er);
    @(negedge clk);
    start = 1'b1; dvd = (DW+1)'(-37); dvs = 8'd91;
    @(negedge clk);
    start = 1'b1; dvd = 9'd5; dvs = 8'd7;
    repeat (3) @(negedge clk);
    start = 1'b0; dvd = 9'd2; dvs = 8'd200;
    while (!done) @(negedge clk);
    chk("R6 quotient", longint'($signed(quo)), eq);
    chk("R6 remainder", longint'(rem), er);
  endtask

  task automatic t_hold;
    logic [QW:0]   q0;
    logic [DW-1:0] r0;
    run_div("R7 setup", 50, 201);
    q0 = quo; r0 = rem;
    dvd = 9'd1; dvs = 8'd3;
    repeat (5) @(negedge clk);
    chk("R7 done low", done, 0);
    chk("R7 quotient held", quo, q0);
    chk("R7 remainder held", rem, r0);
  endtask

  initial begin
    #5;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_div("R4 basic", 10, 40);
    run_div("R4 negative", -20, 30);
    t_bounds();
    t_random();
    t_ignore();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule